// File: doc/BRIEF.md
# NOR Flash Word Program Engine

This block writes one bus word into a parallel NOR flash bank through a simple request/acknowledge memory port. For each accepted request it first reads the word already stored at the target address. An optional byte merge stage builds the word to program from that read: it places a run of source bytes at a chosen byte lane and keeps every other lane as it is in the flash. The engine then refuses the request if programming would need a 0 turned back into a 1.

If the target can take the word, the engine sends the command writes for one of two device families. The first family expects unlock cycles at fixed bank offsets. The second family takes its commands at the target address and reports through a status register. After the data write the engine polls the target until bit 7 of every device lane shows completion, or until a cycle budget runs out. It then runs the family's clean-up writes and returns a two-bit result code together with a one-cycle `done` pulse.

The bus word holds `DW/LANE_W` devices side by side. Commands are copied into the low byte of every device lane, and the status bits are tested in every lane.

Top module: `nor_word_prog`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `fl_valid` are 0.
- R2: A request is taken only when `busy` is 0. `busy` is 1 from the cycle after acceptance until the cycle in which `done` is 1. `done` lasts exactly one cycle. `req_valid` seen while busy has no effect on the bus writes or on the result.
- R3: The first bus access is a read of `req_addr`. If `(current & word) != word`, the result is 2 (not erased) and no bus write is issued.
- R4: In the unlock family (`req_status_fam`=0) the writes are 0xAA at BANK_BASE+0x555, 0x55 at BANK_BASE+0x2AA, 0xA0 at BANK_BASE+0x555, and then the word at `req_addr`. Each command byte sits in bits [7:0] of every 16-bit lane, with the upper byte of the lane 0.
- R5: The unlock family is complete when bit 7 of each lane of the read-back equals bit 7 of the same lane of the written word. The result is then 0, and no further write is issued.
- R6: In the status family (`req_status_fam`=1) the writes are 0x50, 0xFF, 0x40 and then the word, all at `req_addr`.
- R7: The status family is complete when bit 7 of every lane reads 1. The result is 1 if bit 4 of any lane is 1 in that read, and 0 otherwise. The engine then writes 0x50 and then 0xFF at `req_addr`.
- R8: If polling lasts TIMEOUT_CYC cycles without completion, the result is 1. The unlock family then gets 0xF0 at `req_addr`. The status family gets 0xB0 followed by 0x50 and 0xFF.
- R9: The byte lanes of a word are numbered from 0 at bits [31:24] downward. Source byte k, counted from the most significant byte of `req_data`, goes to lane `req_off`+k for k < `req_len`. Lanes outside that span, including any span that runs past lane 3, keep the value read from flash.
- R10: While `fl_valid` is 1 and `fl_ready` is 0, `fl_valid`, `fl_write`, `fl_addr` and `fl_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_status_fam | input | 1 | 0 selects the unlock family, 1 the status family |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Source bytes, first byte most significant |
| req_off | input | OFFW | First byte lane written (lane 0 = MSB) |
| req_len | input | LENW | Number of source bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout or failure, 2 not erased |
| fl_valid | output | 1 | Flash bus access request |
| fl_write | output | 1 | Access is a write |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid with fl_ready |
| fl_ready | input | 1 | Access accepted |

## Verification
The bench goes after the bit-7 comparison in the unlock family by programming words whose bit 7 is 0 in some lanes. A design that tested for a plain 1 would stop polling too early, or would never finish and report a timeout. Some words have one bit cleared inside the written span while the other lanes are erased; if the erase check looked at only part of the word or at the wrong lanes, bus writes would appear where none are expected. Merges at the top lane, in the middle, and past the last lane show any reversed lane order or missing clip as a wrong data write. Timeouts in both families check that the family-specific abort and clean-up writes follow in the right order.

// File: rtl/nwp_pkg.sv
package nwp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_JUDGE,
      ST_ISSUE,
      ST_POLL,
      ST_TAIL
   } nwp_state_e;

   typedef enum logic {
      FAM_UNLOCK = 1'b0,
      FAM_STATUS = 1'b1
   } nwp_fam_e;

   localparam logic [1:0] RC_OK         = 2'd0;
   localparam logic [1:0] RC_FAIL       = 2'd1;
   localparam logic [1:0] RC_NOT_ERASED = 2'd2;

   localparam logic [7:0] OP_UNLK1   = 8'hAA;
   localparam logic [7:0] OP_UNLK2   = 8'h55;
   localparam logic [7:0] OP_PROG_U  = 8'hA0;
   localparam logic [7:0] OP_CLRSTAT = 8'h50;
   localparam logic [7:0] OP_READARR = 8'hFF;
   localparam logic [7:0] OP_PROG_S  = 8'h40;
   localparam logic [7:0] OP_RESET_U = 8'hF0;
   localparam logic [7:0] OP_SUSPEND = 8'hB0;

   localparam logic [11:0] OFS_UNLK1 = 12'h555;
   localparam logic [11:0] OFS_UNLK2 = 12'h2AA;

endpackage

// File: rtl/nwp_byte_merge.sv
module nwp_byte_merge #(
   parameter int DW       = 32,
   parameter int MERGE_EN = 1,
   parameter int OFFW     = 2,
   parameter int LENW     = 3
) (
   input  logic [DW-1:0]   cur,
   input  logic [DW-1:0]   src,
   input  logic [OFFW-1:0] off,
   input  logic [LENW-1:0] len,
   output logic [DW-1:0]   merged
);
   localparam int NB = DW / 8;

   if (DW % 8 != 0) begin : g_bad_width
      $error("nwp_byte_merge: DW must be a whole number of bytes");
   end

   if (MERGE_EN != 0) begin : g_merge
      always_comb begin
         merged = cur;
         for (int i = 0; i < NB; i++) begin
            int rel;
            rel = i - int'(off);
            if (rel >= 0 && rel < int'(len)) begin
               merged[(NB-1-i)*8 +: 8] = src[(NB-1-rel)*8 +: 8];
            end
         end
      end
   end else begin : g_whole
      logic unused_merge_in;
      assign unused_merge_in = ^{cur, off, len};
      assign merged = src;
   end

endmodule

// File: rtl/nwp_seq_table.sv
module nwp_seq_table
   import nwp_pkg::*;
#(
   parameter int              AW        = 24,
   parameter int              DW        = 32,
   parameter int              LANE_W    = 16,
   parameter logic [AW-1:0]   BANK_BASE = '0
) (
   input  logic          fam_status,
   input  logic          in_tail,
   input  logic [1:0]    step,
   input  logic [AW-1:0] dest,
   input  logic [DW-1:0] word,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data,
   output logic          last
);
   localparam int NLANE = DW / LANE_W;
   localparam logic [AW-1:0] ADR_U1 = BANK_BASE + AW'(OFS_UNLK1);
   localparam logic [AW-1:0] ADR_U2 = BANK_BASE + AW'(OFS_UNLK2);

   function automatic logic [DW-1:0] spread(input logic [7:0] op);
      logic [DW-1:0] v;
      v = '0;
      for (int l = 0; l < NLANE; l++) v[l*LANE_W +: 8] = op;
      return v;
   endfunction

   always_comb begin
      addr = dest;
      data = word;
      last = 1'b0;
      if (!in_tail) begin
         last = (step == 2'd3);
         if (!fam_status) begin
            unique case (step)
               2'd0:    begin addr = ADR_U1; data = spread(OP_UNLK1);  end
               2'd1:    begin addr = ADR_U2; data = spread(OP_UNLK2);  end
               2'd2:    begin addr = ADR_U1; data = spread(OP_PROG_U); end
               default: begin addr = dest;   data = word;              end
            endcase
         end else begin
            unique case (step)
               2'd0:    data = spread(OP_CLRSTAT);
               2'd1:    data = spread(OP_READARR);
               2'd2:    data = spread(OP_PROG_S);
               default: data = word;
            endcase
         end
      end else if (!fam_status) begin
         data = spread(OP_RESET_U);
         last = 1'b1;
      end else begin
         unique case (step)
            2'd0:    data = spread(OP_SUSPEND);
            2'd1:    data = spread(OP_CLRSTAT);
            default: begin data = spread(OP_READARR); last = 1'b1; end
         endcase
      end
   end

endmodule

// File: rtl/nwp_poll_check.sv
module nwp_poll_check #(
   parameter int DW     = 32,
   parameter int LANE_W = 16
) (
   input  logic          fam_status,
   input  logic [DW-1:0] rd,
   input  logic [DW-1:0] word,
   output logic          complete,
   output logic          failed
);
   localparam int NLANE = DW / LANE_W;

   logic [NLANE-1:0] lane_ok;
   logic [NLANE-1:0] lane_err;

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      localparam int B7 = l * LANE_W + 7;
      localparam int B4 = l * LANE_W + 4;
      assign lane_ok[l]  = fam_status ? rd[B7] : (rd[B7] == word[B7]);
      assign lane_err[l] = rd[B4];
   end

   assign complete = &lane_ok;
   assign failed   = |lane_err;

endmodule

// File: rtl/nor_word_prog.sv
module nor_word_prog
   import nwp_pkg::*;
#(
   parameter int            AW          = 24,
   parameter int            DW          = 32,
   parameter int            LANE_W      = 16,
   parameter int            TIMEOUT_CYC = 100000,
   parameter int            MERGE_EN    = 1,
   parameter logic [AW-1:0] BANK_BASE   = '0,
   localparam int           NB          = DW / 8,
   localparam int           OFFW        = (NB > 1) ? $clog2(NB) : 1,
   localparam int           LENW        = $clog2(NB + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_status_fam,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_data,
   input  logic [OFFW-1:0] req_off,
   input  logic [LENW-1:0] req_len,
   output logic            busy,
   output logic            done,
   output logic [1:0]      result,
   output logic            fl_valid,
   output logic            fl_write,
   output logic [AW-1:0]   fl_addr,
   output logic [DW-1:0]   fl_wdata,
   input  logic [DW-1:0]   fl_rdata,
   input  logic            fl_ready
);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [TW-1:0] TMO_LIM = TW'(TIMEOUT_CYC);

   if (LANE_W < 8 || DW % LANE_W != 0) begin : g_bad_lane
      $error("nor_word_prog: LANE_W must be >= 8 and divide DW");
   end
   if (TIMEOUT_CYC < 1) begin : g_bad_tmo
      $error("nor_word_prog: TIMEOUT_CYC must be positive");
   end

   nwp_state_e      state_q;
   logic            fam_q;
   logic [AW-1:0]   dest_q;
   logic [DW-1:0]   src_q;
   logic [OFFW-1:0] off_q;
   logic [LENW-1:0] len_q;
   logic [DW-1:0]   cur_q;
   logic [DW-1:0]   word_q;
   logic [1:0]      step_q;
   logic [TW-1:0]   tmo_q;
   logic [1:0]      res_q;
   logic            done_q;

   logic [DW-1:0]   merged;
   logic [AW-1:0]   tbl_addr;
   logic [DW-1:0]   tbl_data;
   logic            tbl_last;
   logic            poll_complete;
   logic            poll_failed;
   logic            hs;

   nwp_byte_merge #(
      .DW(DW), .MERGE_EN(MERGE_EN), .OFFW(OFFW), .LENW(LENW)
   ) u_merge (
      .cur(cur_q), .src(src_q), .off(off_q), .len(len_q), .merged(merged)
   );

   nwp_seq_table #(
      .AW(AW), .DW(DW), .LANE_W(LANE_W), .BANK_BASE(BANK_BASE)
   ) u_table (
      .fam_status(fam_q), .in_tail(state_q == ST_TAIL), .step(step_q),
      .dest(dest_q), .word(word_q),
      .addr(tbl_addr), .data(tbl_data), .last(tbl_last)
   );

   nwp_poll_check #(
      .DW(DW), .LANE_W(LANE_W)
   ) u_poll (
      .fam_status(fam_q), .rd(fl_rdata), .word(word_q),
      .complete(poll_complete), .failed(poll_failed)
   );

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign result   = res_q;
   assign fl_valid = (state_q == ST_FETCH) || (state_q == ST_ISSUE) ||
                     (state_q == ST_POLL)  || (state_q == ST_TAIL);
   assign fl_write = (state_q == ST_ISSUE) || (state_q == ST_TAIL);
   assign fl_addr  = fl_write ? tbl_addr : dest_q;
   assign fl_wdata = fl_write ? tbl_data : '0;
   assign hs       = fl_valid && fl_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fam_q   <= 1'b0;
         dest_q  <= '0;
         src_q   <= '0;
         off_q   <= '0;
         len_q   <= '0;
         cur_q   <= '0;
         word_q  <= '0;
         step_q  <= '0;
         tmo_q   <= '0;
         res_q   <= RC_OK;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  fam_q   <= req_status_fam;
                  dest_q  <= req_addr;
                  src_q   <= req_data;
                  off_q   <= req_off;
                  len_q   <= req_len;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (hs) begin
                  cur_q   <= fl_rdata;
                  state_q <= ST_JUDGE;
               end
            end
            ST_JUDGE: begin
               if ((cur_q & merged) != merged) begin
                  res_q   <= RC_NOT_ERASED;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  word_q  <= merged;
                  step_q  <= 2'd0;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (hs) begin
                  if (tbl_last) begin
                     tmo_q   <= '0;
                     state_q <= ST_POLL;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
            end
            ST_POLL: begin
               if (tmo_q != TMO_LIM) tmo_q <= tmo_q + 1'b1;
               if (hs) begin
                  if (poll_complete) begin
                     if (fam_q == FAM_STATUS) begin
                        res_q   <= poll_failed ? RC_FAIL : RC_OK;
                        step_q  <= 2'd1;
                        state_q <= ST_TAIL;
                     end else begin
                        res_q   <= RC_OK;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                  end else if (tmo_q == TMO_LIM) begin
                     res_q   <= RC_FAIL;
                     step_q  <= 2'd0;
                     state_q <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               if (hs) begin
                  if (tbl_last) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10: a pending access is held until the flash accepts it
   p_hold_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fl_valid && !fl_ready |=> fl_valid && $stable(fl_write) &&
                                 $stable(fl_addr) && $stable(fl_wdata));

   // R2: completion is a single-cycle pulse
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: the target read never drives a write
   p_fetch_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FETCH |-> !fl_write && fl_addr == dest_q);

   // R8: the poll budget counter never passes its limit
   p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_POLL |-> tmo_q <= TMO_LIM);

   // R7: the final read-mode write of the status family ends the request
   p_status_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_TAIL && fam_q == FAM_STATUS && step_q == 2'd2 && hs |=> done);

   // R3: only defined result codes are reported
   p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result != 2'd3);

endmodule

// File: tb/nor_word_prog_test.sv
module nor_word_prog_test;
   localparam int AW = 24;
   localparam int DW = 32;
   localparam logic [AW-1:0] BASE = 24'h040000;
   localparam logic [15:0] HANG = 16'hFFFF;

   typedef struct packed {
      logic        fam;
      logic [1:0]  off;
      logic [2:0]  len;
      logic [31:0] cur;
      logic [31:0] src;
      logic [15:0] busy;
      logic        err;
      logic [1:0]  code;
      logic [31:0] word;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, 3'd4, 32'hFFFFFFFF, 32'h12345678, 16'd2, 1'b0, 2'd0, 32'h12345678},
      '{1'b1, 2'd0, 3'd4, 32'hFFFFFFFF, 32'hA5A50F0F, 16'd3, 1'b0, 2'd0, 32'hA5A50F0F},
      '{1'b1, 2'd0, 3'd4, 32'hFFFFFFFF, 32'hDEADBEEF, 16'd1, 1'b1, 2'd1, 32'hDEADBEEF},
      '{1'b0, 2'd0, 3'd4, 32'h0000FFFF, 32'h0001FFFF, 16'd0, 1'b0, 2'd2, 32'h0001FFFF},
      '{1'b0, 2'd1, 3'd2, 32'hFFFFFFFF, 32'hABCD0000, 16'd0, 1'b0, 2'd0, 32'hFFABCDFF},
      '{1'b1, 2'd3, 3'd1, 32'h123456FF, 32'h5A000000, 16'd1, 1'b0, 2'd0, 32'h1234565A},
      '{1'b0, 2'd2, 3'd4, 32'h0F0FFFFF, 32'h98765432, 16'd0, 1'b0, 2'd0, 32'h0F0F9876},
      '{1'b1, 2'd0, 3'd1, 32'h7FFFFFFF, 32'h80000000, 16'd0, 1'b0, 2'd2, 32'h80FFFFFF},
      '{1'b0, 2'd0, 3'd4, 32'hFFFFFFFF, 32'h00000000, 16'd3, 1'b0, 2'd0, 32'h00000000},
      '{1'b0, 2'd0, 3'd4, 32'hFFFFFFFF, 32'hCAFEF00D, HANG,  1'b0, 2'd1, 32'hCAFEF00D},
      '{1'b1, 2'd0, 3'd4, 32'hFFFFFFFF, 32'h0BADF00D, HANG,  1'b0, 2'd1, 32'h0BADF00D}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_status_fam = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [1:0]    req_off = '0;
   logic [2:0]    req_len = '0;
   logic          busy, done;
   logic [1:0]    result;
   logic          fl_valid, fl_write;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata;
   logic [DW-1:0] fl_rdata;
   logic          fl_ready = 1'b0;

   always #5 clk = ~clk;

   nor_word_prog #(
      .AW(AW), .DW(DW), .LANE_W(16), .TIMEOUT_CYC(40), .MERGE_EN(1), .BANK_BASE(BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_status_fam(req_status_fam),
      .req_addr(req_addr), .req_data(req_data), .req_off(req_off), .req_len(req_len),
      .busy(busy), .done(done), .result(result),
      .fl_valid(fl_valid), .fl_write(fl_write), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_rdata(fl_rdata), .fl_ready(fl_ready)
   );

   // flash model: logs writes, answers reads
   logic          mdl_clear = 1'b0;
   logic          mdl_fam = 1'b0;
   logic          mdl_err = 1'b0;
   logic [15:0]   mdl_busy = '0;
   logic [31:0]   mdl_cur = '0;
   logic [AW-1:0] log_a [16];
   logic [DW-1:0] log_d [16];
   int            wr_n = 0;
   int            poll_n = 0;

   always @(posedge clk) begin
      fl_ready <= fl_valid && !fl_ready;
      if (mdl_clear) begin
         wr_n   <= 0;
         poll_n <= 0;
      end else if (fl_valid && fl_ready) begin
         if (fl_write) begin
            if (wr_n < 16) begin
               log_a[wr_n] <= fl_addr;
               log_d[wr_n] <= fl_wdata;
            end
            wr_n <= wr_n + 1;
         end else if (wr_n >= 4) begin
            poll_n <= poll_n + 1;
         end
      end
   end

   always_comb begin
      if (wr_n < 4)
         fl_rdata = mdl_cur;
      else if (poll_n < int'(mdl_busy))
         fl_rdata = mdl_fam ? 32'h0 : (log_d[3] ^ 32'h00800080);
      else if (mdl_fam)
         fl_rdata = 32'h00800080 | (mdl_err ? 32'h00100010 : 32'h0);
      else
         fl_rdata = log_d[3];
   end

   int compared = 0;
   int mismatched = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rep(input logic [7:0] b);
      return {8'h00, b, 8'h00, b};
   endfunction

   logic [AW-1:0] exp_a [16];
   logic [DW-1:0] exp_d [16];
   int            exp_n;

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_a[exp_n] = a;
      exp_d[exp_n] = d;
      exp_n++;
   endtask

   task automatic build_exp(input logic fam, input logic [AW-1:0] dest, input logic [31:0] w,
                            input logic [1:0] code, input bit hung);
      exp_n = 0;
      if (code == 2'd2) return;
      if (!fam) begin
         push(BASE + 24'h555, rep(8'hAA));
         push(BASE + 24'h2AA, rep(8'h55));
         push(BASE + 24'h555, rep(8'hA0));
         push(dest, w);
         if (hung) push(dest, rep(8'hF0));
      end else begin
         push(dest, rep(8'h50));
         push(dest, rep(8'hFF));
         push(dest, rep(8'h40));
         push(dest, w);
         if (hung) push(dest, rep(8'hB0));
         push(dest, rep(8'h50));
         push(dest, rep(8'hFF));
      end
   endtask

   task automatic run_one(input vec_t v, input logic [AW-1:0] dest, input bit intrude,
                          output logic [1:0] code, output bit seen);
      seen = 1'b0;
      code = 2'd3;
      @(negedge clk);
      mdl_clear = 1'b1;
      mdl_cur   = v.cur;
      mdl_fam   = v.fam;
      mdl_busy  = v.busy;
      mdl_err   = v.err;
      @(negedge clk);
      mdl_clear      = 1'b0;
      req_valid      = 1'b1;
      req_status_fam = v.fam;
      req_addr       = dest;
      req_data       = v.src;
      req_off        = v.off;
      req_len        = v.len;
      @(negedge clk);
      chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
      req_valid = intrude;
      req_data  = ~v.src;
      req_addr  = dest + 24'd5;
      req_status_fam = ~v.fam;
      for (int c = 0; c < 3000; c++) begin
         if (c == 2) req_valid = 1'b0;
         if (done) begin
            seen = 1'b1;
            code = result;
            break;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R2 done lasts one cycle", 64'(done), 64'd0);
   endtask

   task automatic check_writes(input string req);
      bit ok;
      ok = (wr_n == exp_n);
      chk(ok, {req, " write count"}, 64'(wr_n), 64'(exp_n));
      for (int k = 0; k < exp_n && ok; k++) begin
         if (log_a[k] != exp_a[k] || log_d[k] != exp_d[k]) begin
            chk(1'b0, {req, " write content"}, {8'h0, log_a[k], log_d[k]}, {8'h0, exp_a[k], exp_d[k]});
            ok = 1'b0;
         end
      end
      if (ok) chk(1'b1, {req, " write content"}, 64'd0, 64'd0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      summary();
      $finish;
   end

   initial begin
      logic [1:0] code;
      bit seen;
      string tag;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !fl_valid, "R1 during reset", {busy, done, fl_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fl_valid, "R1 after reset", {busy, done, fl_valid}, 64'd0);

      // table walk: R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [AW-1:0] dest;
         v = VECS[i];
         dest = BASE + 24'h000200 + 24'(i * 2);
         tag = v.code == 2'd2 ? "R3" : (v.busy == HANG ? "R8" :
               (v.fam ? (v.err ? "R7" : "R6") : (v.len != 3'd4 || v.off != 0 ? "R9" : "R4/R5")));
         run_one(v, dest, 1'b0, code, seen);
         chk(seen, {tag, " done seen"}, 64'(seen), 64'd1);
         chk(code == v.code, {tag, " result code"}, 64'(code), 64'(v.code));
         build_exp(v.fam, dest, v.word, v.code, v.busy == HANG);
         check_writes(tag);
      end

      // R2: a request presented while busy is ignored
      begin
         vec_t v;
         v = VECS[0];
         run_one(v, BASE + 24'h000300, 1'b1, code, seen);
         chk(seen && code == 2'd0, "R2 intruding request result", 64'(code), 64'd0);
         build_exp(v.fam, BASE + 24'h000300, v.word, 2'd0, 1'b0);
         check_writes("R2 intruding request");
         @(negedge clk);
         chk(!busy && !fl_valid, "R2 idle after run", {busy, fl_valid}, 64'd0);
      end

      // R10: bus held during wait states (first access waits one cycle)
      begin
         vec_t v;
         logic [AW-1:0] a0;
         v = VECS[1];
         @(negedge clk);
         mdl_clear = 1'b1; mdl_cur = v.cur; mdl_fam = v.fam; mdl_busy = v.busy; mdl_err = v.err;
         @(negedge clk);
         mdl_clear = 1'b0; req_valid = 1'b1; req_status_fam = v.fam;
         req_addr = BASE + 24'h000400; req_data = v.src; req_off = v.off; req_len = v.len;
         @(negedge clk);
         req_valid = 1'b0;
         a0 = fl_addr;
         chk(fl_valid && !fl_ready && !fl_write, "R10 read pending", {fl_valid, fl_ready, fl_write}, 64'h4);
         @(negedge clk);
         chk(fl_valid && fl_addr == a0, "R10 held address", 64'(fl_addr), 64'(a0));
         for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
         chk(result == 2'd0, "R10 run result", 64'(result), 64'd0);
      end

      summary();
      $finish;
   end

endmodule